// File: doc/BRIEF.md
# Triple-Redundant Result Voter with Channel Health Tracking

This block sits behind three redundant compute channels that work on the same input. Each channel presents a result word with a valid strobe. The block produces the value that at least two channels agree on, and it finds the channel that disagreed. Each channel has a health state. The first time a channel is outvoted, it gets a restart request and is left out of voting until it reports ready. If it is outvoted again before it has earned a clean record, it is shut out for good.

Once a channel has been shut out, or while one is restarting, the two remaining channels run as a duplex pair. Their results are compared and a fault is flagged when they differ. The pair's primary result is what goes out. An external error-detect input hands the primary role to the standby channel. Isolation is cleared only by reset. One case is accepted by design: when two channels fail with the same wrong value, the one correct channel loses the vote and is the channel that gets restarted.

Top module: `tmr_voter`

## Requirements
- R1: When all three channels take part and at least two result words are equal, the next cycle shows vote_valid high and vote_data equal to the agreed word.
- R2: A vote takes place only in a cycle where every participating channel (neither isolated nor restarting) has its ch_valid bit set. Otherwise vote_valid is low the next cycle and vote_data holds its value.
- R3: If three participating channels all present different words, the next cycle shows fault_nomaj high and vote_valid low. vote_data keeps its previous value and no restart is requested.
- R4: A healthy channel that is the only one outvoted receives a one-cycle pulse on its restart_req bit (bit i for channel i). From then on it is excluded from voting until its ch_ready bit is seen.
- R5: A channel that is outvoted again after it has reported ready, and before its record has been cleared, gets its isolated bit set with no restart pulse.
- R6: After CLEAR_AFTER agreeing votes following its ready, a restarted channel counts as healthy again. Its next disagreement then produces a new restart pulse and not isolation.
- R7: With exactly two channels taking part, unequal words raise fault_mismatch with vote_valid high. The primary's word is passed out, and the primary is the lower-indexed channel unless R8 applies.
- R8: An err_detect pulse while two channels take part makes the higher-indexed channel of the pair the primary, starting with the next vote. This holds until all three channels take part again.
- R9: An isolated channel's valid and data have no effect on any output, and its isolated bit stays set until reset.
- R10: Reset clears every output, every health state and isolation. When two channels agree on a value against the third, the third is restarted even if its word was the correct one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_valid | input | 3 | Result-valid strobe per channel |
| ch0_data | input | W | Result word of channel 0 |
| ch1_data | input | W | Result word of channel 1 |
| ch2_data | input | W | Result word of channel 2 |
| ch_ready | input | 3 | Per-channel ready after restart |
| err_detect | input | 1 | External error detect; swaps the duplex primary |
| vote_valid | output | 1 | Voted result present |
| vote_data | output | W | Voted (or primary) result word |
| fault_nomaj | output | 1 | Three-way disagreement, no majority |
| fault_mismatch | output | 1 | Duplex pair disagreed |
| restart_req | output | 3 | One-cycle restart pulse per channel |
| isolated | output | 3 | Channel permanently excluded |

## Verification
The in-module assertions check the following on every cycle. At most one restart pulse and at most one isolated channel exist at any time. Isolation never clears. The two fault flags never occur together. A no-majority cycle never emits a result and leaves vote_data unchanged. A restart request never goes to an isolated channel. Several things can only be shown by the bench's scenario sequences, because each depends on a history of votes: moving from strike to isolation, clearing a strike after the agreement count, the double-fault corner case, the primary handover on err_detect, and exclusion of a restarting channel.

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int W = 16,
  parameter int CLEAR_AFTER = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   ch_valid,
  input  logic [W-1:0] ch0_data,
  input  logic [W-1:0] ch1_data,
  input  logic [W-1:0] ch2_data,
  input  logic [2:0]   ch_ready,
  input  logic         err_detect,
  output logic         vote_valid,
  output logic [W-1:0] vote_data,
  output logic         fault_nomaj,
  output logic         fault_mismatch,
  output logic [2:0]   restart_req,
  output logic [2:0]   isolated
);
  localparam int CW = $clog2(CLEAR_AFTER + 1);
  localparam logic [CW-1:0] LAST = CW'(CLEAR_AFTER - 1);

  typedef enum logic [1:0] {H_OK, H_RESTART, H_WATCH, H_ISO} hstate_t;

  hstate_t      st  [3];
  logic [CW-1:0] cnt [3];
  logic [W-1:0] d   [3];
  logic [2:0]   part, minor, agree;
  logic         trio, fire, nomaj, pair_mm, swap;
  logic         e01, e02, e12;
  logic [1:0]   lo, hi;
  logic [W-1:0] sel;

  assign d[0] = ch0_data;
  assign d[1] = ch1_data;
  assign d[2] = ch2_data;

  assign e01 = d[0] == d[1];
  assign e02 = d[0] == d[2];
  assign e12 = d[1] == d[2];

  assign trio  = &part;
  assign fire  = (part != 3'b000) && ((ch_valid & part) == part);
  assign nomaj = trio && !e01 && !e02 && !e12;
  assign minor = trio ? {e01 && !e02, e02 && !e01, e12 && !e01} : 3'b000;

  assign lo      = part[0] ? 2'd0 : 2'd1;
  assign hi      = part[2] ? 2'd2 : 2'd1;
  assign pair_mm = !trio && (d[lo] != d[hi]);

  always_comb begin
    if (trio) sel = (e12 && !e01) ? d[1] : d[0];
    else      sel = swap ? d[hi] : d[lo];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vote_valid     <= 1'b0;
      vote_data      <= '0;
      fault_nomaj    <= 1'b0;
      fault_mismatch <= 1'b0;
      swap           <= 1'b0;
    end else begin
      vote_valid     <= fire && !nomaj;
      fault_nomaj    <= fire && nomaj;
      fault_mismatch <= fire && pair_mm;
      if (fire && !nomaj) vote_data <= sel;
      if (trio)            swap <= 1'b0;
      else if (err_detect) swap <= 1'b1;
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_ch
    assign part[i]     = (st[i] == H_OK) || (st[i] == H_WATCH);
    assign isolated[i] = st[i] == H_ISO;
    assign agree[i]    = fire && part[i] && !minor[i] && !nomaj && !pair_mm;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st[i]          <= H_OK;
        cnt[i]         <= '0;
        restart_req[i] <= 1'b0;
      end else begin
        restart_req[i] <= fire && minor[i] && (st[i] == H_OK);
        case (st[i])
          H_OK:      if (fire && minor[i]) st[i] <= H_RESTART;
          H_RESTART: if (ch_ready[i]) begin
                       st[i]  <= H_WATCH;
                       cnt[i] <= '0;
                     end
          H_WATCH:   if (fire && minor[i]) st[i] <= H_ISO;
                     else if (agree[i]) begin
                       if (cnt[i] == LAST) begin
                         st[i]  <= H_OK;
                         cnt[i] <= '0;
                       end else begin
                         cnt[i] <= cnt[i] + 1'b1;
                       end
                     end
          default:   st[i] <= H_ISO;
        endcase
      end
    end
  end

  // R4
  one_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(restart_req));

  // R9
  iso_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(isolated) & ~isolated) == 3'b000));

  // R5
  single_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isolated) <= 1);

  // R3
  nomaj_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_nomaj |-> (!vote_valid && $stable(vote_data) && restart_req == 3'b000));

  // R7
  mismatch_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_mismatch |-> (vote_valid && !fault_nomaj));

  // R4
  restart_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_req & isolated) == 3'b000);
endmodule

// File: tb/tmr_voter_bench.sv
`timescale 1ns/100ps
module tmr_voter_bench;
  localparam int W = 8;

  typedef struct {
    string      tag;
    logic       vv;
    logic [7:0] vd;
    logic       nm;
    logic       mm;
    logic [2:0] rr;
    logic [2:0] iso;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] ch_valid = '0, ch_ready = '0;
  logic [W-1:0] a = '0, b = '0, c = '0;
  logic err = 1'b0;
  logic vv, nm, mm;
  logic [W-1:0] vd;
  logic [2:0] rr, iso;
  int checks = 0, errors = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  tmr_voter #(.W(W), .CLEAR_AFTER(2)) u_tmr_voter (
    .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid),
    .ch0_data(a), .ch1_data(b), .ch2_data(c),
    .ch_ready(ch_ready), .err_detect(err),
    .vote_valid(vv), .vote_data(vd), .fault_nomaj(nm),
    .fault_mismatch(mm), .restart_req(rr), .isolated(iso));

  function automatic exp_t mk(string t, logic v, logic [7:0] dv, logic n, logic m,
                              logic [2:0] r, logic [2:0] s);
    exp_t e;
    e.tag = t; e.vv = v; e.vd = dv; e.nm = n; e.mm = m; e.rr = r; e.iso = s;
    return e;
  endfunction

  task automatic step(input logic [2:0] v, input logic [7:0] x, input logic [7:0] y,
                      input logic [7:0] z, input logic [2:0] rdy, input logic e_in,
                      input exp_t e);
    @(negedge clk);
    ch_valid = v; a = x; b = y; c = z; ch_ready = rdy; err = e_in;
    q.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ch_valid = '0; ch_ready = '0; err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (vv !== e.vv || (e.vv && vd !== e.vd) || (!e.vv && vd !== e.vd) ||
          nm !== e.nm || mm !== e.mm || rr !== e.rr || iso !== e.iso) begin
        errors++;
        $display("FAIL %s: got vv=%0b vd=%0d nm=%0b mm=%0b rr=%b iso=%b exp vv=%0b vd=%0d nm=%0b mm=%0b rr=%b iso=%b",
                 e.tag, vv, vd, nm, mm, rr, iso, e.vv, e.vd, e.nm, e.mm, e.rr, e.iso);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    checks++;
    if (vv !== 1'b0 || vd !== '0 || nm !== 1'b0 || mm !== 1'b0 || rr !== 3'b0 || iso !== 3'b0) begin
      errors++;
      $display("FAIL R10 reset: got vv=%0b vd=%0d nm=%0b mm=%0b rr=%b iso=%b exp all zero",
               vv, vd, nm, mm, rr, iso);
    end
    step(3'b111, 5, 5, 5, 0, 0, mk("R1 unanimous",           1, 5, 0, 0, 3'b000, 3'b000));
    step(3'b011, 6, 6, 6, 0, 0, mk("R2 missing valid",       0, 5, 0, 0, 3'b000, 3'b000));
    step(3'b111, 1, 2, 3, 0, 0, mk("R3 no majority",         0, 5, 1, 0, 3'b000, 3'b000));
    step(3'b111, 7, 7, 9, 0, 0, mk("R4 minority restart",    1, 7, 0, 0, 3'b100, 3'b000));
    step(3'b111, 3, 4, 3, 0, 0, mk("R7 pair mismatch",       1, 3, 0, 1, 3'b000, 3'b000));
    step(3'b011, 6, 6, 0, 0, 0, mk("R4 restarting excluded", 1, 6, 0, 0, 3'b000, 3'b000));
    step(3'b000, 0, 0, 0, 3'b100, 0, mk("R4 ready idle",     0, 6, 0, 0, 3'b000, 3'b000));
    step(3'b111, 8, 8, 8, 0, 0, mk("R1 rejoined",            1, 8, 0, 0, 3'b000, 3'b000));
    step(3'b111, 9, 9, 9, 0, 0, mk("R6 second agree",        1, 9, 0, 0, 3'b000, 3'b000));
    step(3'b111, 1, 1, 2, 0, 0, mk("R6 cleared restarts",    1, 1, 0, 0, 3'b100, 3'b000));
    step(3'b000, 0, 0, 0, 3'b100, 0, mk("R6 ready idle",     0, 1, 0, 0, 3'b000, 3'b000));
    step(3'b111, 4, 4, 5, 0, 0, mk("R5 isolate",             1, 4, 0, 0, 3'b000, 3'b100));
    step(3'b011, 1, 2, 0, 0, 0, mk("R7 lower primary",       1, 1, 0, 1, 3'b000, 3'b100));
    step(3'b011, 5, 5, 0, 0, 1, mk("R8 err cycle",           1, 5, 0, 0, 3'b000, 3'b100));
    step(3'b011, 3, 4, 0, 0, 0, mk("R8 standby primary",     1, 4, 0, 1, 3'b000, 3'b100));
    step(3'b111, 6, 6, 99, 0, 0, mk("R9 isolated data",      1, 6, 0, 0, 3'b000, 3'b100));
    step(3'b100, 0, 0, 7, 0, 0, mk("R9 isolated valid",      0, 6, 0, 0, 3'b000, 3'b100));
    step(3'b000, 0, 0, 0, 0, 0, mk("R9 sticky",              0, 6, 0, 0, 3'b000, 3'b100));
    wait (q.size() == 0);
    do_reset();
    step(3'b000, 0, 0, 0, 0, 0, mk("R10 iso cleared",        0, 0, 0, 0, 3'b000, 3'b000));
    step(3'b111, 7, 9, 9, 0, 0, mk("R10 double fault",       1, 9, 0, 0, 3'b001, 3'b000));
    step(3'b000, 0, 0, 0, 0, 0, mk("R4 pulse ends",          0, 9, 0, 0, 3'b000, 3'b000));
    wait (q.size() == 0);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule